// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block derives an audio bit clock or master clock from a faster parent clock. It lives entirely in the parent clock domain. Software programs a single 32-bit control word. That word holds an integer part, a half-step bit and an 8-bit fraction counted in 255ths. Together they give a divide ratio of twice the integer, plus the half-step, plus the fraction over 255. The divided clock is a registered level output.

Every output period lasts the integer part of the ratio in parent cycles. The fraction is kept in a modulo-255 accumulator that advances once per period. When the accumulator wraps, the coming period is one parent cycle longer. Over many periods the mean ratio therefore matches the programmed value.

A new control word takes effect only at a period boundary. Gating the output off lets the current high phase finish first. An output post-divider of two can be selected in I2S mode and is bypassed in SPDIF mode. Computing a control word for a wanted frequency is left to software.

Top module: `audio_frac_div`

## Requirements
- R1: Out of reset, `clk_out` is low, the control word reads back as 0x0200FF00 (output gated), and the output stays low until a write enables it.
- R2: `cfg_rdata` returns exactly the last word written, reserved bits included, from the cycle after the write strobe, and holds it while no write is made.
- R3: With fraction 0, each output period lasts B = 2·I + H parent cycles (I = bits 23:16, H = bit 24). The period starts with a high phase of floor(P/2) cycles and ends with a low phase.
- R4: The fraction F (bits 7:0) is added once per period to an accumulator that starts at 0 when the output is enabled. When the sum reaches 255, 255 is subtracted and that period is B+1 cycles long.
- R5: When B is below 2 (I = 0), the block uses B = 2 and ignores the fraction.
- R6: Bit 25 is an active-low enable: 0 runs the divider and 1 gates `clk_out` low.
- R7: When the enable is withdrawn during a high phase, that high phase runs to its full length and the output then stays low. The accumulator and the period counter restart from 0 at the next enable.
- R8: A control word written mid-period does not change the period in progress. It sets the length of the next period.
- R9: In I2S mode (`spdif_sel` = 0), bit 28 = 1 gives a post-divider of 1 and bit 28 = 0 doubles every period length. In SPDIF mode (`spdif_sel` = 1), bit 28 has no effect and the post-divider is 1.
- R10: The denominator field (bits 15:8, nominally 0xFF) is stored for readback and has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spdif_sel | input | 1 | 1 selects SPDIF mode, in which bit 28 is ignored; 0 selects I2S mode |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Current control word |
| clk_out | output | 1 | Divided clock |

## Verification
The bench uses the default 8-bit integer and 8-bit fraction fields. With these widths, ratios from 2 to about 12 cover every behaviour: the clamp, the half-step, fraction patterns that stretch every third period, and post-divider doubling. All of them show up within a few dozen parent cycles per period. The fractions 85 and 200 give stretch sequences that the bench's own accumulator model predicts period by period. Those sequences also expose whether the accumulator is cleared on re-enable.

// File: rtl/afd_pkg.sv
// Package: field positions and reset value of the fractional divider control word.
// Assumes a 32-bit control word. Fields that the hardware decodes sit at fixed bits.
package afd_pkg;
    localparam int CFG_W      = 32;
    localparam int FRAC_LSB   = 0;
    localparam int DEN_LSB    = 8;
    localparam int INT_LSB    = 16;
    localparam int HALF_BIT   = 24;
    localparam int GATE_BIT   = 25;
    localparam int POST1_BIT  = 28;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0200_FF00;
endpackage

// File: rtl/afd_ratio_decode.sv
// Module: splits the control word into a base period, a fraction, a doubling flag and a run flag.
// Assumes the field positions from afd_pkg. A base period below 2 is clamped to 2 with no fraction.
module afd_ratio_decode #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8,
    localparam int BASE_W = INT_W + 1
) (
    input  logic [afd_pkg::CFG_W-1:0] cfg,
    input  logic                      spdif_sel,
    output logic [BASE_W-1:0]         base,
    output logic [FRAC_W-1:0]         frac,
    output logic                      dbl,
    output logic                      run
);
    logic [BASE_W-1:0] raw_base;

    // Form 2*I + H, clamp illegal ratios, and decode the mode bits.
    always_comb begin
        raw_base = {cfg[afd_pkg::INT_LSB +: INT_W], cfg[afd_pkg::HALF_BIT]};
        if (raw_base < BASE_W'(2)) begin
            base = BASE_W'(2);
            frac = '0;
        end else begin
            base = raw_base;
            frac = cfg[afd_pkg::FRAC_LSB +: FRAC_W];
        end
        dbl = !spdif_sel && !cfg[afd_pkg::POST1_BIT];
        run = !cfg[afd_pkg::GATE_BIT];
    end
endmodule

// File: rtl/afd_frac_acc.sv
// Module: modulo (2^FRAC_W - 1) fraction accumulator, stepped once per output period.
// Assumes step and clear never coincide. wrap reports whether the next step overflows.
module afd_frac_acc #(
    parameter int FRAC_W = 8,
    localparam int SUM_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] frac,
    input  logic              step,
    input  logic              clear,
    output logic              wrap,
    output logic [FRAC_W-1:0] acc
);
    localparam logic [SUM_W-1:0] DEN = SUM_W'((2 ** FRAC_W) - 1);

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] next_sum;

    // Add the fraction and reduce modulo the denominator.
    always_comb begin
        sum      = {1'b0, acc} + {1'b0, frac};
        wrap     = (sum >= DEN);
        next_sum = wrap ? (sum - DEN) : sum;
    end

    // Hold the accumulated remainder; reset when the output stops.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= next_sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/afd_period_gen.sv
// Module: counts one output period at a time and drives the divided clock high for the first half.
// Assumes the offered length is at least 2. It is sampled only when a period starts (take).
module afd_period_gen #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             take,
    output logic             stop,
    output logic             clk_out,
    output logic             busy,
    output logic [CNT_W-1:0] cur_len
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi_len;
    logic             last;
    logic             hi_done;

    // Detect the period end, the high-phase end, and the start and stop events.
    always_comb begin
        last    = busy && (cnt == cur_len - CNT_W'(1));
        hi_done = !clk_out || ((cnt + CNT_W'(1)) >= hi_len);
        take    = run && (!busy || last);
        stop    = busy && !take && (last || (!run && hi_done));
    end

    // Sequence the counter and the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            clk_out <= 1'b0;
            cnt     <= '0;
            cur_len <= CNT_W'(2);
            hi_len  <= CNT_W'(1);
        end else if (take) begin
            busy    <= 1'b1;
            clk_out <= 1'b1;
            cnt     <= '0;
            cur_len <= len;
            hi_len  <= len >> 1;
        end else if (stop) begin
            busy    <= 1'b0;
            clk_out <= 1'b0;
            cnt     <= '0;
        end else if (busy) begin
            cnt     <= cnt + CNT_W'(1);
            clk_out <= (cnt + CNT_W'(1)) < hi_len;
        end
    end
endmodule

// File: rtl/audio_frac_div.sv
// Module: fractional audio clock divider top. Holds the control word and joins the decoder,
// the accumulator and the period generator. Assumes everything runs on the parent clock.
module audio_frac_div #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8,
    localparam int BASE_W = INT_W + 1,
    localparam int CNT_W  = BASE_W + 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spdif_sel,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        clk_out
);
    logic [31:0]       cfg_q;
    logic [BASE_W-1:0] base;
    logic [FRAC_W-1:0] frac;
    logic              dbl;
    logic              run;
    logic              wrap;
    logic [FRAC_W-1:0] acc;
    logic              take;
    logic              stop;
    logic              busy;
    logic [CNT_W-1:0]  cur_len;
    logic [BASE_W:0]   stretched;
    logic [CNT_W-1:0]  next_len;

    // Store the control word exactly as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= afd_pkg::CFG_RESET;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    assign cfg_rdata = cfg_q;

    afd_ratio_decode #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_decode (
        .cfg       (cfg_q),
        .spdif_sel (spdif_sel),
        .base      (base),
        .frac      (frac),
        .dbl       (dbl),
        .run       (run)
    );

    afd_frac_acc #(.FRAC_W(FRAC_W)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .frac  (frac),
        .step  (take),
        .clear (stop),
        .wrap  (wrap),
        .acc   (acc)
    );

    // Length of the next period: base plus stretch, then the optional post-divider.
    always_comb begin
        stretched = {1'b0, base} + {{BASE_W{1'b0}}, wrap};
        next_len  = dbl ? {stretched, 1'b0} : {1'b0, stretched};
    end

    afd_period_gen #(.CNT_W(CNT_W)) i_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .len     (next_len),
        .take    (take),
        .stop    (stop),
        .clk_out (clk_out),
        .busy    (busy),
        .cur_len (cur_len)
    );
endmodule

// File: rtl/audio_frac_div_chk.sv
// Module: assertion checker bound to audio_frac_div. It watches the ports and the shared internal state.
// Assumes the synchronous active-low reset of the top.
module audio_frac_div_chk #(
    parameter int CNT_W  = 11,
    parameter int FRAC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              clk_out,
    input logic              busy,
    input logic [CNT_W-1:0]  cur_len,
    input logic [FRAC_W-1:0] acc
);
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    p_gated_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[25] && !clk_out) |=> !clk_out);

    p_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_len >= CNT_W'(2)));

    p_acc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc < FRAC_W'((2 ** FRAC_W) - 1));
endmodule

bind audio_frac_div audio_frac_div_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .clk_out   (clk_out),
    .busy      (busy),
    .cur_len   (cur_len),
    .acc       (acc)
);

// File: tb/test_audio_frac_div.sv
// Directed bench for audio_frac_div: one task per scenario, each task checking its own results.
module test_audio_frac_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spdif_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        clk_out;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    audio_frac_div i_audio_frac_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .spdif_sel (spdif_sel),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .clk_out   (clk_out)
    );

    // Build a control word from its fields.
    function automatic logic [31:0] cw(int i, bit h, int f, bit p1, int den, bit gate);
        logic [31:0] w;
        w = '0;
        w[7:0]   = f[7:0];
        w[15:8]  = den[7:0];
        w[23:16] = i[7:0];
        w[24]    = h;
        w[25]    = gate;
        w[28]    = p1;
        return w;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic go_idle();
        wr(cw(1, 0, 0, 1, 255, 1));
        repeat (40) @(negedge clk);
    endtask

    // Measure one period starting at the next high sample.
    task automatic meas(output int hi, output int len);
        hi = 0;
        len = 0;
        while (!clk_out) @(negedge clk);
        while (clk_out) begin hi++; @(negedge clk); end
        while (!clk_out) begin len++; @(negedge clk); end
        len += hi;
    endtask

    // Check n periods against a bench model of base plus fraction stretch.
    task automatic run_pattern(string req, int base, int f, int mult, int n);
        int acc = 0;
        for (int k = 0; k < n; k++) begin
            int hi;
            int len;
            int exp_len;
            acc += f;
            exp_len = base;
            if (acc >= 255) begin
                acc -= 255;
                exp_len = base + 1;
            end
            exp_len = exp_len * mult;
            meas(hi, len);
            chk(len == exp_len, req, len, exp_len);
            chk(hi == exp_len / 2, req, hi, exp_len / 2);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cfg_rdata == 32'h0200_FF00, "R1 reset word", int'(cfg_rdata), 32'h0200_FF00);
        begin
            int highs = 0;
            for (int k = 0; k < 30; k++) begin
                if (clk_out) highs++;
                @(negedge clk);
            end
            chk(highs == 0, "R1 output low after reset", highs, 0);
        end
    endtask

    task automatic t_readback();
        wr(32'hF3C3_1234);
        chk(cfg_rdata == 32'hF3C3_1234, "R2 readback", int'(cfg_rdata), 32'hF3C3_1234);
        repeat (5) @(negedge clk);
        chk(cfg_rdata == 32'hF3C3_1234, "R2 readback held", int'(cfg_rdata), 32'hF3C3_1234);
        go_idle();
    endtask

    task automatic t_integer();
        wr(cw(3, 0, 0, 1, 255, 0));
        run_pattern("R3 integer ratio 6", 6, 0, 1, 3);
        go_idle();
        wr(cw(2, 1, 0, 1, 255, 0));
        run_pattern("R3 half-step ratio 5", 5, 0, 1, 3);
        go_idle();
    endtask

    task automatic t_fraction();
        wr(cw(2, 0, 85, 1, 255, 0));
        run_pattern("R4 fraction 85/255 base 4", 4, 85, 1, 6);
        go_idle();
        wr(cw(3, 1, 200, 1, 255, 0));
        run_pattern("R4 fraction 200/255 base 7", 7, 200, 1, 6);
        go_idle();
    endtask

    task automatic t_clamp();
        wr(cw(0, 0, 100, 1, 255, 0));
        run_pattern("R5 clamp I=0 H=0", 2, 0, 1, 4);
        go_idle();
        wr(cw(0, 1, 50, 1, 255, 0));
        run_pattern("R5 clamp I=0 H=1", 2, 0, 1, 4);
        go_idle();
    endtask

    task automatic t_gate();
        int highs = 0;
        wr(cw(3, 0, 0, 1, 255, 1));
        for (int k = 0; k < 40; k++) begin
            if (clk_out) highs++;
            @(negedge clk);
        end
        chk(highs == 0, "R6 gated word keeps output low", highs, 0);
        wr(cw(3, 0, 0, 1, 255, 0));
        run_pattern("R6 enable bit 0 runs", 6, 0, 1, 2);
        go_idle();
    endtask

    task automatic t_disable_mid();
        int hi_cnt;
        int late = 0;
        wr(cw(5, 0, 0, 1, 255, 0));
        while (!clk_out) @(negedge clk);
        hi_cnt = 2;
        wr(cw(5, 0, 0, 1, 255, 1));
        while (clk_out) begin hi_cnt++; @(negedge clk); end
        chk(hi_cnt == 5, "R7 high phase completes", hi_cnt, 5);
        for (int k = 0; k < 40; k++) begin
            if (clk_out) late++;
            @(negedge clk);
        end
        chk(late == 0, "R7 low after disable", late, 0);
        wr(cw(2, 0, 85, 1, 255, 0));
        run_pattern("R7 before disable", 4, 85, 1, 2);
        go_idle();
        wr(cw(2, 0, 85, 1, 255, 0));
        run_pattern("R7 accumulator restarts", 4, 85, 1, 3);
        go_idle();
    endtask

    task automatic t_boundary();
        int hi;
        int len;
        wr(cw(5, 0, 0, 1, 255, 0));
        meas(hi, len);
        chk(len == 10, "R8 first period", len, 10);
        wr(cw(2, 0, 0, 1, 255, 0));
        meas(hi, len);
        chk(len == 8, "R8 current period keeps old ratio", len, 8);
        meas(hi, len);
        chk(len == 4, "R8 next period uses new ratio", len, 4);
        chk(hi == 2, "R8 next high phase", hi, 2);
        go_idle();
    endtask

    task automatic t_postdiv();
        spdif_sel = 1'b0;
        wr(cw(3, 0, 0, 0, 255, 0));
        run_pattern("R9 I2S post-divider 2", 6, 0, 2, 3);
        go_idle();
        spdif_sel = 1'b1;
        wr(cw(3, 0, 0, 0, 255, 0));
        run_pattern("R9 SPDIF ignores bit 28", 6, 0, 1, 3);
        go_idle();
        spdif_sel = 1'b0;
    endtask

    task automatic t_denominator();
        wr(cw(3, 0, 0, 1, 0, 0));
        run_pattern("R10 denominator 0x00", 6, 0, 1, 2);
        go_idle();
        wr(cw(3, 0, 85, 1, 8'h5A, 0));
        run_pattern("R10 denominator 0x5A", 6, 85, 1, 4);
        go_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_integer();
        t_fraction();
        t_clamp();
        t_gate();
        t_disable_mid();
        t_boundary();
        t_postdiv();
        t_denominator();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #750000;
        errors++;
        checks++;
        $display("FAIL watchdog expired R1..R10 unfinished actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule